// File: doc/BRIEF.md
# Pin Interrupt Router with Level Hold-Off

This block takes a set of interrupt input pins and routes each one as a delivery message. Each pin has a 64-bit redirection entry that software programs through a simple register port. The entry sets the vector, the delivery mode, the destination mode, the destination, the pin polarity, the trigger mode and a mask. A request register records which pins are pending. Unmasked pending pins are offered one at a time on a valid/ready delivery port. The lowest pin index is offered first.

A level-triggered pin stays pending for as long as its input is active. To stop it from flooding the delivery port, the block sets a per-entry remote-pending flag when it delivers such a pin. The pin is then held off until an end-of-interrupt broadcast arrives whose vector matches the entry. When the broadcast clears the flag and the pin is still active and unmasked, the pin is offered again on the next cycle without any further stimulus. An edge-triggered pin is pending from an active edge until its delivery is accepted.

Top module: `pin_irq_router`

## Requirements
- R1: After reset, every entry reads back as 64'h0000_0000_0001_0000 (only the mask bit set) and `dlv_valid` is low.
- R2: The entry bits are: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13] (1 = active low), remote-pending [14], trigger [15] (0 = edge, 1 = level), mask [16] and destination [63:56]. A delivery carries the vector, mode, destination mode and destination of the offered pin.
- R3: On an edge-triggered pin, an inactive-to-active transition makes the pin pending one cycle later. The pin is offered once and is no longer pending after its delivery is accepted, even if the input stays active.
- R4: For a level-triggered pin, the pending bit follows the input XOR polarity. When its delivery is accepted, remote-pending is set (read back as bit 14 = 1), and the pin is not offered again while that bit is set.
- R5: An end-of-interrupt broadcast clears remote-pending in every entry whose vector equals the broadcast vector. An entry with a different vector keeps its remote-pending bit.
- R6: When remote-pending is cleared while the level pin is still active and unmasked, the pin is offered in the cycle after the broadcast.
- R7: A masked entry is never offered. A pin that became pending while masked is offered after the mask is cleared.
- R8: Pending pins are offered in ascending pin order, with one delivery accepted per cycle while `dlv_ready` is high.
- R9: While `dlv_ready` is low, the offered delivery and its fields stay unchanged.
- R10: Bit 14 cannot be written by software. A write carrying 1 or 0 in bit 14 leaves the read-back value of remote-pending unchanged.
- R11: With polarity 1, a low input level is the active state.
- R12: When a level pin has gone inactive before its broadcast, clearing remote-pending causes no new delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt input pins, synchronous to clk |
| cfg_wr | input | 1 | Write strobe for one redirection entry |
| cfg_addr | input | IDX_W | Entry index for read and write |
| cfg_wdata | input | 64 | Entry write data (bit 14 ignored) |
| cfg_rdata | output | 64 | Entry at cfg_addr, including remote-pending |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the broadcast |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | Receiver accepts the offered delivery |
| dlv_pin | output | IDX_W | Pin index of the offered delivery |
| dlv_vector | output | 8 | Vector of the offered delivery |
| dlv_mode | output | 3 | Delivery mode of the offered delivery |
| dlv_dest_mode | output | 1 | Destination mode of the offered delivery |
| dlv_dest | output | 8 | Destination of the offered delivery |

## Verification
The bench builds the router at its default of 24 pins, which makes the address field 5 bits wide. At that size pin 0, pins in the middle of the range and the top pin 23 can all be reached. This lets the ordering test run from a low index up to the last entry, and lets writes to an entry outside the pin range be observed. With 8-bit vectors, a broadcast vector can differ from a live entry's vector in a single low bit, so a near-miss broadcast can be shown to leave the hold-off in place.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int unsigned ENT_W     = 64;
   localparam int unsigned VEC_W     = 8;
   localparam int unsigned MODE_W    = 3;
   localparam int unsigned DEST_W    = 8;
   localparam int unsigned VEC_LSB   = 0;
   localparam int unsigned MODE_LSB  = 8;
   localparam int unsigned DMODE_BIT = 11;
   localparam int unsigned POL_BIT   = 13;
   localparam int unsigned RIRR_BIT  = 14;
   localparam int unsigned TRIG_BIT  = 15;
   localparam int unsigned MASK_BIT  = 16;
   localparam int unsigned DEST_LSB  = 56;

   localparam logic [ENT_W-1:0] RESET_ENTRY = ENT_W'(1) << MASK_BIT;
   localparam logic [ENT_W-1:0] RIRR_SEL    = ENT_W'(1) << RIRR_BIT;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              dest_mode;
      logic [MODE_W-1:0] mode;
      logic [VEC_W-1:0]  vector;
   } irq_msg_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned NUM_PINS = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] pol_i,
   input  logic [NUM_PINS-1:0] trig_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] irr_o
);
   logic [NUM_PINS-1:0] act;
   logic [NUM_PINS-1:0] act_q;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] irr_q;

   assign act   = pin_i ^ pol_i;
   assign rise  = act & ~act_q;
   assign irr_o = irr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         irr_q <= '0;
      end else begin
         act_q <= act;
         for (int i = 0; i < NUM_PINS; i++) begin
            if (trig_i[i])      irr_q[i] <= act[i];
            else if (rise[i])   irr_q[i] <= 1'b1;
            else if (clr_i[i])  irr_q[i] <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
      AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig_i[g] && clr_i[g] && !rise[g]) |=> !irr_o[g]); // R3
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned IDX_W    = 5
) (
   input  logic [NUM_PINS-1:0] req_i,
   output logic                any_o,
   output logic [IDX_W-1:0]    idx_o
);
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
   import irq_router_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned IDX_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [IDX_W-1:0]    cfg_addr,
   input  logic [ENT_W-1:0]    cfg_wdata,
   output logic [ENT_W-1:0]    cfg_rdata,
   input  logic                fire_i,
   input  logic [IDX_W-1:0]    fire_idx_i,
   input  logic                eoi_valid,
   input  logic [VEC_W-1:0]    eoi_vector,
   input  logic [IDX_W-1:0]    sel_idx_i,
   output irq_msg_t            sel_msg_o,
   output logic [NUM_PINS-1:0] mask_o,
   output logic [NUM_PINS-1:0] trig_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] rirr_o
);
   logic [ENT_W-1:0]    ent_q [NUM_PINS];
   logic [NUM_PINS-1:0] rirr_q;
   logic [NUM_PINS-1:0] rirr_d;
   logic [NUM_PINS-1:0] vec_hit;
   logic                addr_ok;
   logic [ENT_W-1:0]    sel_ent;

   assign addr_ok = 32'(cfg_addr) < NUM_PINS;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_fld
      assign mask_o[g]  = ent_q[g][MASK_BIT];
      assign trig_o[g]  = ent_q[g][TRIG_BIT];
      assign pol_o[g]   = ent_q[g][POL_BIT];
      assign vec_hit[g] = ent_q[g][VEC_LSB +: VEC_W] == eoi_vector;
   end
   assign rirr_o = rirr_q;

   always_comb begin
      rirr_d = rirr_q;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (fire_i && fire_idx_i == IDX_W'(i) && trig_o[i])
            rirr_d[i] = 1'b1;
         else if (eoi_valid && rirr_q[i] && vec_hit[i])
            rirr_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rirr_q <= '0;
         for (int i = 0; i < NUM_PINS; i++) ent_q[i] <= RESET_ENTRY;
      end else begin
         rirr_q <= rirr_d;
         for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_wr && cfg_addr == IDX_W'(i))
               ent_q[i] <= cfg_wdata & ~RIRR_SEL;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (addr_ok)
         cfg_rdata = ent_q[cfg_addr] | (rirr_q[cfg_addr] ? RIRR_SEL : '0);
   end

   assign sel_ent             = ent_q[sel_idx_i];
   assign sel_msg_o.vector    = sel_ent[VEC_LSB +: VEC_W];
   assign sel_msg_o.mode      = sel_ent[MODE_LSB +: MODE_W];
   assign sel_msg_o.dest_mode = sel_ent[DMODE_BIT];
   assign sel_msg_o.dest      = sel_ent[DEST_LSB +: DEST_W];

   AST_LEVEL_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && trig_o[fire_idx_i]) |=> rirr_o[$past(fire_idx_i)]); // R4
   AST_SW_NO_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !fire_i && !eoi_valid) |=> $stable(rirr_o)); // R10

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_eoi_chk
      AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_valid && rirr_o[g] && vec_hit[g] &&
          !(fire_i && fire_idx_i == IDX_W'(g))) |=> !rirr_o[g]); // R5
   end
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
   import irq_router_pkg::*;
#(
   parameter  int unsigned NUM_PINS = 24,
   localparam int unsigned IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                cfg_wr,
   input  logic [IDX_W-1:0]    cfg_addr,
   input  logic [63:0]         cfg_wdata,
   output logic [63:0]         cfg_rdata,
   input  logic                eoi_valid,
   input  logic [7:0]          eoi_vector,
   output logic                dlv_valid,
   input  logic                dlv_ready,
   output logic [IDX_W-1:0]    dlv_pin,
   output logic [7:0]          dlv_vector,
   output logic [2:0]          dlv_mode,
   output logic                dlv_dest_mode,
   output logic [7:0]          dlv_dest
);
   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("pin_irq_router: NUM_PINS must lie in 1..256");
   end
   if (ENT_W != 64 || DEST_LSB + DEST_W > ENT_W) begin : g_bad_layout
      $error("pin_irq_router: entry layout does not fit 64 bits");
   end

   logic [NUM_PINS-1:0] mask, trig, pol, rirr, irr, eligible, clr_edge;
   logic                fire;
   irq_msg_t            msg;

   irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .fire_i     (fire),
      .fire_idx_i (dlv_pin),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .sel_idx_i  (dlv_pin),
      .sel_msg_o  (msg),
      .mask_o     (mask),
      .trig_o     (trig),
      .pol_o      (pol),
      .rirr_o     (rirr)
   );

   irq_req_latch #(.NUM_PINS(NUM_PINS)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .pol_i  (pol),
      .trig_i (trig),
      .clr_i  (clr_edge),
      .irr_o  (irr)
   );

   assign eligible = irr & ~mask & ~(trig & rirr);

   irq_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
      .req_i (eligible),
      .any_o (dlv_valid),
      .idx_o (dlv_pin)
   );

   assign fire = dlv_valid & dlv_ready;

   always_comb begin
      clr_edge = '0;
      if (fire) clr_edge[dlv_pin] = ~trig[dlv_pin];
   end

   assign dlv_vector    = msg.vector;
   assign dlv_mode      = msg.mode;
   assign dlv_dest_mode = msg.dest_mode;
   assign dlv_dest      = msg.dest;

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> !mask[dlv_pin]); // R7
   AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> !(trig[dlv_pin] && rirr[dlv_pin])); // R4
   AST_PENDING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> irr[dlv_pin]); // R8
endmodule

// File: tb/tb_pin_irq_router.sv
module tb_pin_irq_router;
   localparam int unsigned N  = 24;
   localparam int unsigned IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic          cfg_wr = 1'b0;
   logic [IW-1:0] cfg_addr = '0;
   logic [63:0]   cfg_wdata = '0;
   logic [63:0]   cfg_rdata;
   logic          eoi_valid = 1'b0;
   logic [7:0]    eoi_vector = '0;
   logic          dlv_valid;
   logic          dlv_ready = 1'b0;
   logic [IW-1:0] dlv_pin;
   logic [7:0]    dlv_vector;
   logic [2:0]    dlv_mode;
   logic          dlv_dest_mode;
   logic [7:0]    dlv_dest;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   pin_irq_router #(.NUM_PINS(N)) dut (.*);

   always #2 clk = ~clk;

   function automatic logic [63:0] ent(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic dmode, input logic pol,
                                       input logic lvl, input logic msk,
                                       input logic [7:0] dest);
      return {dest, 39'd0, msk, lvl, 1'b0, pol, 1'b0, dmode, mode, vec};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [63:0] d);
      cfg_wr = 1'b1; cfg_addr = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [63:0] d);
      cfg_addr = IW'(idx);
      #1 d = cfg_rdata;
   endtask

   task automatic eoi(input logic [7:0] v);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic expect_offer(input int pin, input logic [7:0] vec, input string tag);
      chk(dlv_valid, {tag, " valid"}, 64'(dlv_valid), 1);
      chk(dlv_pin == IW'(pin), {tag, " pin"}, 64'(dlv_pin), 64'(pin));
      chk(dlv_vector == vec, {tag, " vector"}, 64'(dlv_vector), 64'(vec));
   endtask

   task automatic accept(input int pin, input logic [7:0] vec, input string tag);
      expect_offer(pin, vec, tag);
      dlv_ready = 1'b1;
      @(negedge clk);
      dlv_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      rd(0, d);  chk(d == 64'h1_0000, "R1 entry0", d, 64'h1_0000);
      rd(23, d); chk(d == 64'h1_0000, "R1 entry23", d, 64'h1_0000);
      chk(!dlv_valid, "R1 no offer", 64'(dlv_valid), 0);
   endtask

   task automatic t_edge();
      logic [63:0] d;
      wr(3, ent(8'h33, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5));
      pin_in[3] = 1'b1;
      @(negedge clk);
      chk(dlv_mode == 3'd2, "R2 mode", 64'(dlv_mode), 2);
      chk(dlv_dest_mode == 1'b1, "R2 dest mode", 64'(dlv_dest_mode), 1);
      chk(dlv_dest == 8'hA5, "R2 dest", 64'(dlv_dest), 64'hA5);
      accept(3, 8'h33, "R3 edge offer");
      chk(!dlv_valid, "R3 cleared after accept", 64'(dlv_valid), 0);
      @(negedge clk);
      chk(!dlv_valid, "R3 held input no repeat", 64'(dlv_valid), 0);
      rd(3, d); chk(d[14] == 1'b0, "R3 edge no remote bit", 64'(d[14]), 0);
      pin_in[3] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_level();
      logic [63:0] d;
      wr(5, ent(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01));
      pin_in[5] = 1'b1;
      @(negedge clk);
      accept(5, 8'h45, "R4 level offer");
      chk(!dlv_valid, "R4 held off", 64'(dlv_valid), 0);
      rd(5, d); chk(d[14] == 1'b1, "R4 remote bit set", 64'(d[14]), 1);
      wr(5, ent(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01));
      rd(5, d); chk(d[14] == 1'b1, "R10 write 0 ignored", 64'(d[14]), 1);
      chk(!dlv_valid, "R4 still held off", 64'(dlv_valid), 0);
      wr(6, ent(8'h60, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00) | 64'h4000);
      rd(6, d); chk(d[14] == 1'b0, "R10 write 1 ignored", 64'(d[14]), 0);
   endtask

   task automatic t_eoi();
      logic [63:0] d;
      eoi(8'h44);
      chk(!dlv_valid, "R5 mismatch keeps hold", 64'(dlv_valid), 0);
      rd(5, d); chk(d[14] == 1'b1, "R5 mismatch bit kept", 64'(d[14]), 1);
      eoi(8'h45);
      expect_offer(5, 8'h45, "R6 redelivery");
      accept(5, 8'h45, "R6 accept");
      pin_in[5] = 1'b0;
      @(negedge clk);
      eoi(8'h45);
      chk(!dlv_valid, "R12 no redelivery", 64'(dlv_valid), 0);
      rd(5, d); chk(d[14] == 1'b0, "R5 matching clears bit", 64'(d[14]), 0);
   endtask

   task automatic t_mask();
      wr(7, ent(8'h70, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02));
      pin_in[7] = 1'b1;
      repeat (3) @(negedge clk);
      chk(!dlv_valid, "R7 masked silent", 64'(dlv_valid), 0);
      wr(7, ent(8'h70, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02));
      accept(7, 8'h70, "R7 unmask delivers");
      pin_in[7] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_order();
      wr(23, ent(8'h57, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03));
      wr(9,  ent(8'h29, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03));
      wr(2,  ent(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03));
      pin_in[23] = 1'b1; pin_in[9] = 1'b1; pin_in[2] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         expect_offer(2, 8'h22, "R9 stalled offer");
      end
      dlv_ready = 1'b1;
      expect_offer(2, 8'h22, "R8 first");
      @(negedge clk);
      expect_offer(9, 8'h29, "R8 second");
      @(negedge clk);
      expect_offer(23, 8'h57, "R8 third");
      @(negedge clk);
      dlv_ready = 1'b0;
      chk(!dlv_valid, "R8 drained", 64'(dlv_valid), 0);
      pin_in[23] = 1'b0; pin_in[9] = 1'b0; pin_in[2] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_polarity();
      wr(12, ent(8'h6C, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h04));
      @(negedge clk);
      accept(12, 8'h6C, "R11 low level active");
      pin_in[12] = 1'b1;
      @(negedge clk);
      eoi(8'h6C);
      chk(!dlv_valid, "R11 high level inactive", 64'(dlv_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_level();
      t_eoi();
      t_mask();
      t_order();
      t_polarity();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
      $finish;
   end
endmodule